// File: doc/BRIEF.md
# Interrupt Acceptance Gate with Enable Shadow

This block sits beside an instruction pipeline and decides, at every instruction boundary, whether control should divert to a handler and for which class of event. It watches the interrupt-enable flag, a pulse that marks the retirement of an enable-interrupts instruction, a boundary strobe, a level-sensitive maskable request, a non-maskable request and a synchronous exception request. It produces one take strobe with a two-bit cause code. Vector fetch, arbitration among several maskable sources and the handler entry sequence belong to other blocks.

Three rules shape the decision. Maskable requests are honoured only while the enable flag is set. They are held off for one boundary after an enable-interrupts instruction retires, so the instruction after it always runs first. Exceptions and non-maskable requests ignore both the flag and that shadow. Non-maskable requests are caught on their rising edge and remain pending until taken. When several causes are present at once, exceptions win over non-maskable requests, which win over maskable ones.

The decision is combinational from the current inputs and two pieces of state: the pending non-maskable bit and the shadow counter. The number of boundaries covered by the shadow is a parameter that defaults to one.

Top module: `irq_gate`

## Requirements
- R1: `take` is high only in a cycle where `boundary` is high. `take_cause` is 00 whenever `take` is low, and `take` is high exactly when `take_cause` is not 00.
- R2: At a boundary where `intr_req` is 1, `if_flag` is 1, no shadow is active and no higher cause is present, the block takes the event with cause 11.
- R3: While `if_flag` is 0, a maskable request is not taken. An exception at that boundary is still taken with cause 01.
- R4: An `sti_retire` pulse starts a shadow covering the first boundary at or after the pulse, including a boundary in the same cycle. A maskable request is not taken at that boundary, and it is taken at the next boundary.
- R5: Exceptions (cause 01) and non-maskable requests (cause 10) are taken inside the shadow and while `if_flag` is 0.
- R6: A rising edge of `nmi_req` sets a pending bit, which is held across cycles without a boundary and taken with cause 10 at a boundary. Taking it clears the bit, so a level held high is not taken a second time.
- R7: When several causes are present at one boundary, the order is exception (01), then non-maskable (10), then maskable (11). A pending non-maskable event that loses to an exception stays pending.
- R8: The maskable request is level-sensitive and is not stored. A request removed before a boundary is not taken there.
- R9: After reset, no non-maskable event is pending and no shadow is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_flag | input | 1 | Current interrupt-enable flag |
| sti_retire | input | 1 | Pulse: enable-interrupts instruction retired |
| boundary | input | 1 | Instruction boundary strobe |
| intr_req | input | 1 | Maskable interrupt request, level |
| nmi_req | input | 1 | Non-maskable request, edge-captured |
| exc_req | input | 1 | Exception request at this boundary |
| take | output | 1 | Divert to a handler at this boundary |
| take_cause | output | 2 | 00 none, 01 exception, 10 non-maskable, 11 maskable |

## Verification
The checker tests on every cycle the relation between the take strobe and the boundary, the consistency of the cause code, the flag condition on maskable takes, exception priority, that no maskable take happens while a shadow is marked, and that the pending bit clears after a non-maskable take. Only the bench's sequences can show that the shadow ends after exactly one boundary, that a held non-maskable level is not taken twice, that a pending event survives several idle cycles and a lost arbitration, and that a maskable request withdrawn before the boundary leaves no trace.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_EXC  = 2'b01,
    CAUSE_NMI  = 2'b10,
    CAUSE_MASK = 2'b11
  } cause_e;

  // Fixed priority: exception over non-maskable over maskable.
  function automatic cause_e pick_cause(input logic exc_ok,
                                        input logic nmi_ok,
                                        input logic mask_ok);
    cause_e c;
    c = CAUSE_NONE;
    if (mask_ok) c = CAUSE_MASK;
    if (nmi_ok)  c = CAUSE_NMI;
    if (exc_ok)  c = CAUSE_EXC;
    return c;
  endfunction

  // A maskable request is eligible only with the flag set and no shadow.
  function automatic logic mask_eligible(input logic req,
                                         input logic enable,
                                         input logic shadowed);
    return req & enable & ~shadowed;
  endfunction

endpackage

// File: rtl/irq_nmi_catch.sv
module irq_nmi_catch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_req,
  input  logic nmi_taken,
  output logic nmi_rise,
  output logic nmi_pending,
  output logic nmi_pend_q
);
  logic nmi_prev_q;

  assign nmi_rise    = nmi_req & ~nmi_prev_q;
  assign nmi_pending = nmi_pend_q | nmi_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_q <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_req;
      nmi_pend_q <= nmi_pending & ~nmi_taken;
    end
  end
endmodule

// File: rtl/irq_shadow_ctr.sv
module irq_shadow_ctr #(
  parameter int SHADOW_LEN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sti_retire,
  input  logic boundary,
  output logic shadow_active
);
  localparam int CW = $clog2(SHADOW_LEN + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign shadow_active = sti_retire | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (sti_retire) begin
      cnt_d = boundary ? CW'(SHADOW_LEN - 1) : CW'(SHADOW_LEN);
    end else if (boundary && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/irq_cause_pick.sv
module irq_cause_pick
  import irq_gate_pkg::*;
(
  input  logic   boundary,
  input  logic   exc_req,
  input  logic   nmi_pending,
  input  logic   intr_req,
  input  logic   if_flag,
  input  logic   shadow_active,
  output logic   mask_ok,
  output logic   any_take,
  output cause_e cause
);
  logic raw_mask;

  assign raw_mask = mask_eligible(intr_req, if_flag, shadow_active);
  assign mask_ok  = boundary & raw_mask;
  assign any_take = boundary & (exc_req | nmi_pending | raw_mask);

  always_comb begin
    cause = CAUSE_NONE;
    if (boundary) cause = pick_cause(exc_req, nmi_pending, raw_mask);
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_gate_pkg::*;
#(
  parameter int SHADOW_LEN = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       if_flag,
  input  logic       sti_retire,
  input  logic       boundary,
  input  logic       intr_req,
  input  logic       nmi_req,
  input  logic       exc_req,
  output logic       take,
  output logic [1:0] take_cause
);
  logic   nmi_rise;
  logic   nmi_pending;
  logic   nmi_pend_q;
  logic   nmi_taken;
  logic   shadow_active;
  logic   mask_ok;
  logic   any_take;
  cause_e cause;

  irq_nmi_catch u_nmi (
    .clk         (clk),
    .rst_n       (rst_n),
    .nmi_req     (nmi_req),
    .nmi_taken   (nmi_taken),
    .nmi_rise    (nmi_rise),
    .nmi_pending (nmi_pending),
    .nmi_pend_q  (nmi_pend_q)
  );

  irq_shadow_ctr #(.SHADOW_LEN(SHADOW_LEN)) u_shadow (
    .clk           (clk),
    .rst_n         (rst_n),
    .sti_retire    (sti_retire),
    .boundary      (boundary),
    .shadow_active (shadow_active)
  );

  irq_cause_pick u_pick (
    .boundary      (boundary),
    .exc_req       (exc_req),
    .nmi_pending   (nmi_pending),
    .intr_req      (intr_req),
    .if_flag       (if_flag),
    .shadow_active (shadow_active),
    .mask_ok       (mask_ok),
    .any_take      (any_take),
    .cause         (cause)
  );

  assign nmi_taken  = (cause == CAUSE_NMI);
  assign take       = any_take;
  assign take_cause = cause;
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       if_flag,
  input logic       sti_retire,
  input logic       boundary,
  input logic       exc_req,
  input logic       take,
  input logic [1:0] take_cause,
  input logic       shadow_active,
  input logic       nmi_pending,
  input logic       nmi_pend_q
);
  assert_take_on_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |-> !take);

  assert_cause_matches_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take == (take_cause != 2'b00));

  assert_mask_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_cause == 2'b11) |-> if_flag);

  assert_shadow_blocks_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_active || sti_retire) |-> (take_cause != 2'b11));

  assert_exc_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && exc_req) |-> (take_cause == 2'b01));

  assert_nmi_has_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_cause == 2'b10) |-> nmi_pending);

  assert_nmi_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_cause == 2'b10) |=> !nmi_pend_q);

  assert_nmi_over_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && nmi_pending && !exc_req) |-> (take_cause == 2'b10));
endmodule

bind irq_gate irq_gate_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .if_flag       (if_flag),
  .sti_retire    (sti_retire),
  .boundary      (boundary),
  .exc_req       (exc_req),
  .take          (take),
  .take_cause    (take_cause),
  .shadow_active (shadow_active),
  .nmi_pending   (nmi_pending),
  .nmi_pend_q    (nmi_pend_q)
);

// File: tb/irq_gate_bench.sv
module irq_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       if_flag = 1'b0;
  logic       sti_retire = 1'b0;
  logic       boundary = 1'b0;
  logic       intr_req = 1'b0;
  logic       nmi_req = 1'b0;
  logic       exc_req = 1'b0;
  logic       take;
  logic [1:0] take_cause;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0] cause;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  irq_gate u_irq_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .if_flag    (if_flag),
    .sti_retire (sti_retire),
    .boundary   (boundary),
    .intr_req   (intr_req),
    .nmi_req    (nmi_req),
    .exc_req    (exc_req),
    .take       (take),
    .take_cause (take_cause)
  );

  // Driver: one call is one clock cycle of stimulus plus its expected result.
  task automatic step(input logic f, input logic sti, input logic bnd,
                      input logic irq, input logic nmi, input logic exc,
                      input logic [1:0] exp_cause, input string tag);
    exp_t e;
    @(negedge clk);
    if_flag = f; sti_retire = sti; boundary = bnd;
    intr_req = irq; nmi_req = nmi; exc_req = exc;
    e.cause = exp_cause;
    e.tag   = tag;
    sb.push_back(e);
  endtask

  // Monitor: sample mid-low-phase, well away from the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        logic exp_take;
        e = sb.pop_front();
        exp_take = (e.cause != 2'b00);
        total++;
        if (take !== exp_take || take_cause !== e.cause) begin
          bad++;
          $display("FAIL %s: take=%b cause=%b expected take=%b cause=%b",
                   e.tag, take, take_cause, exp_take, e.cause);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    //    if sti bnd irq nmi exc  cause
    step(0, 0, 1, 0, 0, 0, 2'b00, "R9 idle boundary after reset");
    step(1, 0, 0, 1, 0, 0, 2'b00, "R1 no take off boundary");
    step(1, 0, 1, 1, 0, 0, 2'b11, "R2 maskable taken");
    step(0, 0, 1, 1, 0, 0, 2'b00, "R3 maskable ignored with flag clear");
    step(0, 0, 1, 0, 0, 1, 2'b01, "R3 exception with flag clear");
    // shadow started off-boundary
    step(1, 1, 0, 1, 0, 0, 2'b00, "R4 enable pulse, no boundary");
    step(1, 0, 1, 1, 0, 0, 2'b00, "R4 first boundary shadowed");
    step(1, 0, 1, 1, 0, 0, 2'b11, "R4 next boundary allowed");
    // shadow started on a boundary
    step(1, 1, 1, 1, 0, 0, 2'b00, "R4 pulse with boundary shadowed");
    step(1, 0, 1, 1, 0, 0, 2'b11, "R4 boundary after pulse allowed");
    // NMI inside shadow
    step(1, 1, 0, 0, 0, 0, 2'b00, "R5 enable pulse");
    step(1, 0, 1, 1, 1, 0, 2'b10, "R5 NMI inside shadow");
    step(1, 0, 1, 1, 1, 0, 2'b11, "R6 held NMI level not retaken");
    // NMI captured and held while idle
    step(0, 0, 0, 0, 0, 0, 2'b00, "R6 NMI low");
    step(0, 0, 0, 0, 1, 0, 2'b00, "R6 NMI edge off boundary");
    step(0, 0, 0, 0, 0, 0, 2'b00, "R6 NMI pending idle");
    step(0, 0, 1, 0, 0, 0, 2'b10, "R5 pending NMI taken with flag clear");
    step(0, 0, 1, 0, 0, 0, 2'b00, "R6 pending cleared after take");
    // priority
    step(1, 0, 1, 1, 1, 1, 2'b01, "R7 exception beats NMI and maskable");
    step(1, 0, 1, 1, 1, 0, 2'b10, "R7 NMI kept pending then beats maskable");
    step(1, 0, 1, 1, 1, 0, 2'b11, "R7 maskable after higher causes");
    step(1, 1, 1, 1, 1, 1, 2'b01, "R5 exception inside shadow");
    // level-sensitive maskable request
    step(1, 0, 0, 1, 0, 0, 2'b00, "R8 request present off boundary");
    step(1, 0, 1, 0, 0, 0, 2'b00, "R8 withdrawn request not taken");
    step(1, 0, 0, 0, 0, 0, 2'b00, "R1 quiet");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule